// File: doc/BRIEF.md
# APB Completer to Register Strobe Bridge

This block sits between an APB completer port (APB3 or APB4 flavour) and a register file that speaks a simple strobe protocol. When the requester enters the access phase, the bridge raises a one-clock request pulse. With that pulse it passes on a write flag, the byte address, the write data and a per-bit enable mask. It then keeps the transfer stretched by holding ready low. It releases the transfer in the cycle where the register file answers with the acknowledge strobe of the matching kind.

Reads and writes use a single request line, so one address decoder serves both directions. Completions come back on two separate acknowledge strobes, one for reads (with data and error) and one for writes (with error). The two paths can therefore have different, fixed but unknown latencies. A parameter picks the enable-mask variant. It either expands the byte strobes into bit enables, or drives every enable to 1 when the bus has no strobes. The protection attribute input is accepted and has no effect.

Top module: `apb_regbridge`

## Requirements
- R1: The request output `rq_valid` is high for exactly one clock, in the first cycle where `psel` and `penable` are both high. It is low during the setup phase and while idle.
- R2: While a transfer waits for its acknowledge, `rq_valid` stays low even though `psel` and `penable` stay high. The next transfer issues a fresh pulse.
- R3: In the request cycle, `rq_write` equals `pwrite`, `rq_addr` equals `paddr` and `rq_wdata` equals `pwdata`.
- R4: `pready` is low while the acknowledge is outstanding. It is high in the very cycle the matching acknowledge is present, including an acknowledge given in the request cycle itself.
- R5: When a read completes, `prdata` equals `rd_data` and `pslverr` equals `rd_err` in that same cycle. At all other times `prdata` is zero.
- R6: When a write completes, `pslverr` equals `wr_err` in that cycle.
- R7: An acknowledge of the wrong kind (a write acknowledge during a read or a read acknowledge during a write), or any acknowledge while no transfer is pending, leaves `pready` and `pslverr` low.
- R8: With `HAS_STRB`=1, bit i of `rq_biten` equals `pstrb[i/8]`, so byte lane n covers bits 8n to 8n+7.
- R9: With `HAS_STRB`=0, every bit of `rq_biten` is 1, whatever `pstrb` holds.
- R10: `pprot` has no effect on any output.
- R11: After reset, with `psel` low, `rq_valid`, `pready` and `pslverr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access-phase flag |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| pstrb | input | DATA_W/8 | APB byte strobes |
| pprot | input | 3 | APB protection attribute (ignored) |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready |
| pslverr | output | 1 | APB error response |
| rq_valid | output | 1 | One-clock request strobe |
| rq_write | output | 1 | Request is a write |
| rq_addr | output | ADDR_W | Request byte address |
| rq_wdata | output | DATA_W | Request write data |
| rq_biten | output | DATA_W | Request per-bit write enables |
| rd_ack | input | 1 | Read acknowledge strobe |
| rd_data | input | DATA_W | Read data, qualified by rd_ack |
| rd_err | input | 1 | Read error, qualified by rd_ack |
| wr_ack | input | 1 | Write acknowledge strobe |
| wr_err | input | 1 | Write error, qualified by wr_ack |

## Verification
There is no register between the inputs and any result, apart from the single pending-state flop. The request fields are due in the same cycle as the first `penable` cycle. Ready, read data and error are due in the same cycle as the acknowledge. The bench therefore sets inputs just after a rising edge and compares every output with its model at the following falling edge, on every cycle of each transfer. The responder model acknowledges after 0 to 4 cycles, and some runs inject acknowledges of the wrong kind while the bridge waits. A second instance without strobes is checked on the same cycles.

// File: rtl/apb_rb_pkg.sv
package apb_rb_pkg;
   typedef enum logic {
      RB_IDLE = 1'b0,
      RB_WAIT = 1'b1
   } rb_state_e;

   function automatic int rb_lanes(input int data_w);
      return data_w / 8;
   endfunction
endpackage

// File: rtl/apb_rb_lanes.sv
module apb_rb_lanes #(
   parameter int DATA_W   = 32,
   parameter bit HAS_STRB = 1'b1,
   localparam int LANES   = apb_rb_pkg::rb_lanes(DATA_W)
) (
   input  logic [LANES-1:0]  strb,
   output logic [DATA_W-1:0] biten
);
   generate
      if (HAS_STRB) begin : g_strb
         for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign biten[l*8 +: 8] = {8{strb[l]}};
         end
      end else begin : g_nostrb
         logic unused_strb;
         assign unused_strb = ^strb;
         assign biten = '1;
      end
   endgenerate

   // R8/R9 lane check next to the expansion
   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         a_r8_lane_mask: assert (biten[l*8 +: 8] == (HAS_STRB ? {8{strb[l]}} : 8'hFF))
            else $error("R8/R9 lane mask mismatch");
      end
   end
endmodule

// File: rtl/apb_rb_seq.sv
module apb_rb_seq
   import apb_rb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic psel,
   input  logic penable,
   input  logic pwrite,
   input  logic rd_ack,
   input  logic wr_ack,
   output logic req,
   output logic done
);
   rb_state_e state_q, state_d;
   logic access, pending, hit;

   assign access  = psel & penable;
   assign req     = access & (state_q == RB_IDLE);
   assign pending = req | (state_q == RB_WAIT);
   assign hit     = pwrite ? wr_ack : rd_ack;
   assign done    = pending & hit;

   always_comb begin
      state_d = state_q;
      if (done)     state_d = RB_IDLE;
      else if (req) state_d = RB_WAIT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= RB_IDLE;
      else        state_q <= state_d;
   end

   a_r2_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RB_WAIT) |-> !req);
   a_r2_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !done) |=> (state_q == RB_WAIT));
endmodule

// File: rtl/apb_rb_resp.sv
module apb_rb_resp #(
   parameter int DATA_W = 32
) (
   input  logic              done,
   input  logic              pwrite,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_err,
   input  logic              wr_err,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr
);
   assign pready  = done;
   assign prdata  = (done && !pwrite) ? rd_data : '0;
   assign pslverr = done & (pwrite ? wr_err : rd_err);
endmodule

// File: rtl/apb_regbridge.sv
module apb_regbridge #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 32,
   parameter bit HAS_STRB = 1'b1,
   localparam int LANES   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   input  logic [LANES-1:0]  pstrb,
   input  logic [2:0]        pprot,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   output logic              rq_valid,
   output logic              rq_write,
   output logic [ADDR_W-1:0] rq_addr,
   output logic [DATA_W-1:0] rq_wdata,
   output logic [DATA_W-1:0] rq_biten,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_err,
   input  logic              wr_ack,
   input  logic              wr_err
);
   generate
      if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_bad_width
         $error("apb_regbridge: DATA_W must be a positive multiple of 8");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("apb_regbridge: ADDR_W must be at least 1");
      end
   endgenerate

   logic unused_prot;
   assign unused_prot = ^pprot;

   logic done;

   apb_rb_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .rd_ack  (rd_ack),
      .wr_ack  (wr_ack),
      .req     (rq_valid),
      .done    (done)
   );

   apb_rb_lanes #(.DATA_W(DATA_W), .HAS_STRB(HAS_STRB)) u_lanes (
      .strb  (pstrb),
      .biten (rq_biten)
   );

   apb_rb_resp #(.DATA_W(DATA_W)) u_resp (
      .done    (done),
      .pwrite  (pwrite),
      .rd_data (rd_data),
      .rd_err  (rd_err),
      .wr_err  (wr_err),
      .prdata  (prdata),
      .pready  (pready),
      .pslverr (pslverr)
   );

   assign rq_write = pwrite;
   assign rq_addr  = paddr;
   assign rq_wdata = pwdata;

   a_r1_req_in_access: assert property (@(posedge clk) disable iff (!rst_n)
      rq_valid |-> (psel && penable));
   a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_valid && !pready) |=> !rq_valid);
   a_r4_ready_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
      pready |-> (psel && penable && (rd_ack || wr_ack)));
   a_r7_kind_match: assert property (@(posedge clk) disable iff (!rst_n)
      pready |-> (pwrite ? wr_ack : rd_ack));
   a_r5_prdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(pready && !pwrite) |-> (prdata == '0));
   a_r7_err_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      pslverr |-> pready);
endmodule

// File: tb/sim_apb_regbridge.sv
module sim_apb_regbridge;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int NL = DW / 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic psel = 0, penable = 0, pwrite = 0;
   logic [AW-1:0] paddr = '0;
   logic [DW-1:0] pwdata = '0;
   logic [NL-1:0] pstrb = '0;
   logic [2:0] pprot = '0;
   logic rd_ack = 0, rd_err = 0, wr_ack = 0, wr_err = 0;
   logic [DW-1:0] rd_data = '0;

   logic [DW-1:0] prdata, rq_wdata, rq_biten, prdata1, rq_wdata1, rq_biten1;
   logic [AW-1:0] rq_addr, rq_addr1;
   logic pready, pslverr, rq_valid, rq_write;
   logic pready1, pslverr1, rq_valid1, rq_write1;

   int checks = 0;
   int errors = 0;
   bit done_flag = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   apb_regbridge #(.ADDR_W(AW), .DATA_W(DW), .HAS_STRB(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot),
      .prdata(prdata), .pready(pready), .pslverr(pslverr),
      .rq_valid(rq_valid), .rq_write(rq_write), .rq_addr(rq_addr),
      .rq_wdata(rq_wdata), .rq_biten(rq_biten),
      .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
      .wr_ack(wr_ack), .wr_err(wr_err));

   apb_regbridge #(.ADDR_W(AW), .DATA_W(DW), .HAS_STRB(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot),
      .prdata(prdata1), .pready(pready1), .pslverr(pslverr1),
      .rq_valid(rq_valid1), .rq_write(rq_write1), .rq_addr(rq_addr1),
      .rq_wdata(rq_wdata1), .rq_biten(rq_biten1),
      .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
      .wr_ack(wr_ack), .wr_err(wr_err));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] expand(input logic [NL-1:0] s);
      logic [DW-1:0] m;
      for (int b = 0; b < DW; b++) m[b] = s[b/8];
      return m;
   endfunction

   task automatic next_cycle();
      @(posedge clk);
      #1;
   endtask

   // Compare all outputs against the expected state of one cycle
   task automatic cmp(input bit e_req, input bit e_rdy, input logic [DW-1:0] e_rd,
                      input bit e_err);
      @(negedge clk);
      chk(e_req ? "R1 request pulse" : "R2 no request", rq_valid, e_req);
      chk("R4 ready", pready, e_rdy);
      chk("R5 read data", prdata, e_rd);
      chk("R6 error", pslverr, e_err);
      chk("R10 twin ready", pready1, e_rdy);
      if (e_req) begin
         chk("R3 write flag", rq_write, pwrite);
         chk("R3 address", rq_addr, paddr);
         chk("R3 write data", rq_wdata, pwdata);
         chk("R8 strobe expand", rq_biten, expand(pstrb));
         chk("R9 all enables", rq_biten1, {DW{1'b1}});
      end
   endtask

   task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [NL-1:0] s, input logic [2:0] prot, input int lat,
                       input bit err, input bit stray);
      logic [DW-1:0] rv;
      rv = d ^ 32'h5A5A_0F0F;
      psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; pstrb = s; pprot = prot;
      rd_ack = 0; wr_ack = 0; rd_err = 0; wr_err = 0; rd_data = '0;
      cmp(0, 0, '0, 0);
      next_cycle();
      penable = 1;
      for (int k = 0; k <= lat; k++) begin
         rd_ack = 0; wr_ack = 0; rd_err = 0; wr_err = 0; rd_data = '0;
         if (k == lat) begin
            if (wr) begin wr_ack = 1; wr_err = err; end
            else begin rd_ack = 1; rd_data = rv; rd_err = err; end
         end else if (stray) begin
            // R7: wrong-kind acknowledge while waiting
            if (wr) begin rd_ack = 1; rd_data = 32'hDEAD_BEEF; rd_err = 1; end
            else begin wr_ack = 1; wr_err = 1; end
         end
         if (k == lat) cmp(k == 0, 1, wr ? '0 : rv, err);
         else          cmp(k == 0, 0, '0, 0);
         next_cycle();
      end
      psel = 0; penable = 0; rd_ack = 0; wr_ack = 0; rd_err = 0; wr_err = 0; rd_data = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done_flag) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 2 + 1);
      // R11 reset state
      @(negedge clk);
      chk("R11 reset req", rq_valid, 0);
      chk("R11 reset ready", pready, 0);
      chk("R11 reset err", pslverr, 0);
      rst_n = 1;
      next_cycle();
      cmp(0, 0, '0, 0);
      next_cycle();
      // R7: acknowledges with nothing pending
      rd_ack = 1; rd_err = 1; rd_data = 32'h1234_5678; wr_ack = 1; wr_err = 1;
      cmp(0, 0, '0, 0);
      next_cycle();
      rd_ack = 0; wr_ack = 0; rd_err = 0; wr_err = 0; rd_data = '0;
      // main traffic
      xfer(1, 16'h0010, 32'hCAFE_0001, 4'b1111, 3'd0, 1, 0, 0);
      xfer(0, 16'h0014, 32'h0000_1111, 4'b0000, 3'd5, 1, 0, 0);
      xfer(1, 16'h0100, 32'hA5A5_A5A5, 4'b0101, 3'd7, 3, 1, 0);
      xfer(0, 16'h0104, 32'h7777_0000, 4'b1010, 3'd2, 4, 1, 0);
      xfer(0, 16'hFFFC, 32'h0BAD_F00D, 4'b0011, 3'd0, 0, 0, 0);
      xfer(1, 16'h0008, 32'h1357_9BDF, 4'b1000, 3'd3, 0, 1, 0);
      xfer(0, 16'h0020, 32'h2468_ACE0, 4'b1100, 3'd1, 3, 0, 1);
      xfer(1, 16'h0024, 32'hFEDC_BA98, 4'b0001, 3'd6, 2, 0, 1);
      // back-to-back with no idle cycle
      xfer(1, 16'h0030, 32'h0000_00FF, 4'b0010, 3'd0, 2, 0, 0);
      xfer(0, 16'h0034, 32'h0000_FF00, 4'b0100, 3'd4, 2, 1, 0);
      // R10: same read with a different pprot must behave identically
      xfer(0, 16'h0040, 32'h1111_2222, 4'b1111, 3'd0, 1, 0, 0);
      xfer(0, 16'h0040, 32'h1111_2222, 4'b1111, 3'd7, 1, 0, 0);
      next_cycle();
      cmp(0, 0, '0, 0);
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule